// File: doc/BRIEF.md
# Mailbox-commanded I2C master

This block is a single-master I2C controller that a host runs through six 16-bit registers. The host loads one or two outgoing bytes into a data extension register. It then writes a command word that names the 7-bit target, the direction, the byte count (one or two) and whether the bus stays claimed afterwards. The command write starts the transfer straight away. The engine sends START (or a repeated START when the previous command kept the bus), the address byte and the data bytes, and it checks or gives each acknowledge. When it finishes it either sends STOP or parks the bus with SCL held low.

On completion one of three sticky event flags is set: transmit done, receive done or error. Received bytes appear in a read extension register. A level interrupt is raised for any event flag that is enabled. SCL runs at the system clock divided by four times `CLK_DIV`.

The register port is a plain single-cycle write strobe with a combinational read. It has no back-pressure. A command written while the engine is busy is dropped, and the host paces itself with the `busy` pin or with the events. The bus pins are open-drain: each output asks for the line to be pulled low, and the SDA line level comes back on `sda_in`.

Top module: `mbx_i2c_master`

## Requirements
- R1: After reset the event flags and interrupt enables are zero, `irq` and `busy` are low, and neither bus line is pulled low.
- R2: A command write whose bits 15:14 are not 2'b10 is ignored: no bus activity, `busy` stays low, and no event is set.
- R3: Command bit 10 = 1 selects a write. The master sends START, then the address byte {bits 7:1, 0}, then the low byte of the data extension and, when bit 11 = 1, its high byte. Success sets event bit 14 only.
- R4: Command bit 10 = 0 selects a read. The address byte carries R/W = 1, and one byte (bit 11 = 0) or two bytes (bit 11 = 1) are received. The master ACKs every byte but the last, which it NACKs. The first byte lands in bits 7:0 and the second in bits 15:8 of the read extension. Success sets event bit 15 only.
- R5: A NACK to the address byte or to a written byte ends the command with STOP and sets event bit 13 only.
- R6: With command bit 13 = 1 and no error, the master sends no STOP and keeps SCL low afterwards. The next command then opens with a repeated START. With bit 13 = 0, the command ends in STOP and both lines are released.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it alone.
- R8: `irq` is the OR over bits 15:13 of (status AND enable).
- R9: A command write while `busy` is high is ignored.
- R10: Register offsets: 0 status, 1 interrupt enable (bits 15:13), 2 write data extension, 3 command (reads back the last accepted command), 4 read data extension, 5 reads as zero.
- R11: During address, data and acknowledge bits, SDA changes only while SCL is low. Each command therefore produces exactly one START, and at most one STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register word offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| irq | output | 1 | Level interrupt |
| busy | output | 1 | A command is in progress |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The main transfer path is driven through a behavioural target on the bus. Directed commands cover a one-byte write, a two-byte read, a wrong address and a held bus. These separate the two directions, the two byte counts and the ACK versus NACK exits. Seeded random commands then mix target addresses, directions, counts, hold flags, data values and injected data NACKs. That exposes lane swaps, missing final NACKs, stray STOPs between held commands and wrong event bits. Non-native and mid-transfer commands are checked through start counts and the `busy` pin, and the interrupt is checked against several enable masks.

// File: rtl/mbx_i2c_pkg.sv
package mbx_i2c_pkg;

  localparam logic [2:0] OFS_STATUS = 3'd0;
  localparam logic [2:0] OFS_IEN    = 3'd1;
  localparam logic [2:0] OFS_WEXT   = 3'd2;
  localparam logic [2:0] OFS_CMD    = 3'd3;
  localparam logic [2:0] OFS_REXT   = 3'd4;

  localparam int EVT_ERR_BIT = 13;
  localparam int EVT_TX_BIT  = 14;
  localparam int EVT_RX_BIT  = 15;
  localparam int CMD_WR_BIT   = 10;
  localparam int CMD_TWO_BIT  = 11;
  localparam int CMD_HOLD_BIT = 13;
  localparam logic [1:0] CMD_NATIVE = 2'b10;

  typedef struct packed {
    logic [6:0] addr;
    logic       wr;
    logic       two;
    logic       hold;
  } cmd_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_BIT, ST_ACK, ST_STOP
  } eng_state_t;

endpackage

// File: rtl/mbx_i2c_tick.sv
module mbx_i2c_tick #(
  parameter int DIV = 125
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/mbx_i2c_engine.sv
module mbx_i2c_engine
  import mbx_i2c_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        start_i,
  input  cmd_t        cmd_i,
  input  logic [15:0] wbuf_i,
  input  logic        sda_in,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o,
  output logic        rd_o,
  output logic [15:0] rdata_o,
  output logic        scl_lo_o,
  output logic        sda_lo_o
);
  eng_state_t  state_q;
  logic [1:0]  phase_q, bidx_q;
  logic [2:0]  bitn_q;
  logic [7:0]  sh_q;
  cmd_t        cmd_q;
  logic [15:0] wbuf_q, rbuf_q;
  logic        held_q, err_q, done_q;
  logic [1:0]  sync_q;
  logic        scl_d, sda_d, scl_q, sda_q, dphase_q;

  wire        sda_s  = sync_q[1];
  wire [1:0]  nbytes = cmd_q.two ? 2'd2 : 2'd1;
  wire        rxmode = (bidx_q != 2'd0) && !cmd_q.wr;
  wire        last_b = (bidx_q == nbytes);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], sda_in};
  end

  always_comb begin
    scl_d = 1'b0;
    sda_d = 1'b0;
    unique case (state_q)
      ST_IDLE:  scl_d = held_q;
      ST_START: begin
        scl_d = (phase_q == 2'd0) ? held_q : (phase_q == 2'd3);
        sda_d = phase_q[1];
      end
      ST_BIT: begin
        scl_d = (phase_q == 2'd0) || (phase_q == 2'd3);
        sda_d = !rxmode && !sh_q[7];
      end
      ST_ACK: begin
        scl_d = (phase_q == 2'd0) || (phase_q == 2'd3);
        sda_d = rxmode && !last_b;
      end
      ST_STOP: begin
        scl_d = (phase_q == 2'd0);
        sda_d = !phase_q[1];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b0; sda_q <= 1'b0; dphase_q <= 1'b0;
    end else begin
      scl_q <= scl_d; sda_q <= sda_d;
      dphase_q <= (state_q == ST_BIT) || (state_q == ST_ACK);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; phase_q <= '0; bidx_q <= '0; bitn_q <= '0;
      sh_q <= '0; cmd_q <= '0; wbuf_q <= '0; rbuf_q <= '0;
      held_q <= 1'b0; err_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (start_i) begin
          cmd_q <= cmd_i; wbuf_q <= wbuf_i; err_q <= 1'b0;
          phase_q <= '0; state_q <= ST_START;
        end
      end else if (tick) begin
        phase_q <= phase_q + 2'd1;
        if (phase_q == 2'd2) begin
          if (state_q == ST_BIT && rxmode) sh_q <= {sh_q[6:0], sda_s};
          if (state_q == ST_ACK && !rxmode) err_q <= sda_s;
        end
        if (phase_q == 2'd3) begin
          unique case (state_q)
            ST_START: begin
              state_q <= ST_BIT; bidx_q <= '0; bitn_q <= '0; held_q <= 1'b0;
              sh_q <= {cmd_q.addr, !cmd_q.wr};
            end
            ST_BIT: begin
              if (bitn_q == 3'd7) begin
                bitn_q <= '0; state_q <= ST_ACK;
                if (rxmode) begin
                  if (bidx_q == 2'd1) rbuf_q[7:0]  <= sh_q;
                  else                rbuf_q[15:8] <= sh_q;
                end
              end else begin
                bitn_q <= bitn_q + 3'd1;
                if (!rxmode) sh_q <= {sh_q[6:0], 1'b0};
              end
            end
            ST_ACK: begin
              if (!rxmode && err_q) state_q <= ST_STOP;
              else if (last_b) begin
                if (cmd_q.hold) begin
                  state_q <= ST_IDLE; held_q <= 1'b1; done_q <= 1'b1;
                end else state_q <= ST_STOP;
              end else begin
                bidx_q <= bidx_q + 2'd1; state_q <= ST_BIT;
                sh_q <= (bidx_q == 2'd0) ? wbuf_q[7:0] : wbuf_q[15:8];
              end
            end
            ST_STOP: begin
              state_q <= ST_IDLE; held_q <= 1'b0; done_q <= 1'b1;
            end
            default: state_q <= ST_IDLE;
          endcase
        end
      end
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign err_o    = err_q;
  assign rd_o     = !cmd_q.wr;
  assign rdata_o  = rbuf_q;
  assign scl_lo_o = scl_q;
  assign sda_lo_o = sda_q;

  AST_SDA_STEADY_HIGH_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    (dphase_q && !scl_q && $past(!scl_q)) |-> $stable(sda_q)) else $error("sda moved"); // R11
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !held_q) |-> (!scl_q && !sda_q)) else $error("bus not released"); // R6
  AST_HOLD_KEEPS_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && held_q) |-> scl_q) else $error("held bus lost scl"); // R6
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o) else $error("done while busy"); // R3
  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (state_q == ST_IDLE)) else $error("start while busy"); // R9
endmodule

// File: rtl/mbx_i2c_regs.sv
module mbx_i2c_regs
  import mbx_i2c_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        eng_busy,
  input  logic        eng_done,
  input  logic        eng_err,
  input  logic        eng_rd,
  input  logic [15:0] eng_rdata,
  output logic        start_o,
  output cmd_t        cmd_o,
  output logic [15:0] wbuf_o,
  output logic        irq_o
);
  localparam int NEV = 3;

  logic [NEV-1:0] st_q, ien_q, ev_set;
  logic [15:0]    wext_q, cmd_word_q;

  wire wr_cmd = reg_wr && (reg_addr == OFS_CMD);
  wire wr_st  = reg_wr && (reg_addr == OFS_STATUS);

  assign start_o = wr_cmd && (reg_wdata[15:14] == CMD_NATIVE) && !eng_busy;
  assign ev_set  = eng_done ? {!eng_err && eng_rd, !eng_err && !eng_rd, eng_err} : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0; ien_q <= '0; wext_q <= '0; cmd_word_q <= '0;
    end else begin
      st_q <= (st_q & ~(wr_st ? reg_wdata[15:13] : '0)) | ev_set;
      if (reg_wr && reg_addr == OFS_IEN)  ien_q  <= reg_wdata[15:13];
      if (reg_wr && reg_addr == OFS_WEXT) wext_q <= reg_wdata;
      if (start_o) cmd_word_q <= reg_wdata;
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFS_STATUS: reg_rdata = {st_q, 13'd0};
      OFS_IEN:    reg_rdata = {ien_q, 13'd0};
      OFS_WEXT:   reg_rdata = wext_q;
      OFS_CMD:    reg_rdata = cmd_word_q;
      OFS_REXT:   reg_rdata = eng_rdata;
      default:    reg_rdata = '0;
    endcase
  end

  assign cmd_o.addr = reg_wdata[7:1];
  assign cmd_o.wr   = reg_wdata[CMD_WR_BIT];
  assign cmd_o.two  = reg_wdata[CMD_TWO_BIT];
  assign cmd_o.hold = reg_wdata[CMD_HOLD_BIT];
  assign wbuf_o     = wext_q;
  assign irq_o      = |(st_q & ien_q);

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ev_set)) else $error("multiple events"); // R3
  AST_W1C_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st && reg_wdata[EVT_RX_BIT] && !ev_set[2]) |=> !st_q[2]) else $error("w1c"); // R7
  AST_STICKY_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[2] && !(wr_st && reg_wdata[EVT_RX_BIT])) |=> st_q[2]) else $error("sticky"); // R7
  AST_NONNATIVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && reg_wdata[15:14] != CMD_NATIVE && !eng_busy) |=> !eng_busy) else $error("non-native ran"); // R2
endmodule

// File: rtl/mbx_i2c_master.sv
module mbx_i2c_master
  import mbx_i2c_pkg::*;
#(
  parameter int CLK_DIV = 125
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq,
  output logic        busy,
  output logic        scl_drive_low,
  output logic        sda_drive_low,
  input  logic        sda_in
);
  logic        tick, start, done, err, rd;
  cmd_t        cmd;
  logic [15:0] wbuf, rdata;

  mbx_i2c_tick #(.DIV(CLK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  mbx_i2c_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_busy(busy),
    .eng_done(done), .eng_err(err), .eng_rd(rd), .eng_rdata(rdata),
    .start_o(start), .cmd_o(cmd), .wbuf_o(wbuf), .irq_o(irq)
  );

  mbx_i2c_engine u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start_i(start), .cmd_i(cmd),
    .wbuf_i(wbuf), .sda_in(sda_in), .busy_o(busy), .done_o(done),
    .err_o(err), .rd_o(rd), .rdata_o(rdata),
    .scl_lo_o(scl_drive_low), .sda_lo_o(sda_drive_low)
  );
endmodule

// File: tb/mbx_i2c_master_tb.sv
module mbx_i2c_master_tb;
  localparam logic [6:0] SLV = 7'h5A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic irq, busy, scl_lo, sda_lo;
  logic s_oe = 1'b0;
  wire scl = !scl_lo;
  wire sda = !(sda_lo || s_oe);

  mbx_i2c_master #(.CLK_DIV(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .busy(busy),
    .scl_drive_low(scl_lo), .sda_drive_low(sda_lo), .sda_in(sda)
  );

  always #10 clk = !clk;

  // behavioural target: mode 0 idle, 1 address, 2 receive, 3 transmit, 4 ignore
  int s_mode = 0, s_bc = 0, s_starts = 0, s_stops = 0, s_nrx = 0, s_ntx = 0;
  logic s_after = 1'b0, s_mnack = 1'b0, s_nack_data = 1'b0;
  logic [7:0] s_sh = '0, s_txb = '0, s_next = 8'hA5;
  logic [7:0] s_rx [4];
  logic [7:0] s_tx [4];

  always @(negedge sda) if (scl === 1'b1) begin
    s_starts++; s_mode = 1; s_bc = 0; s_after = 1'b0; s_oe = 1'b0; s_nrx = 0; s_ntx = 0;
  end
  always @(posedge sda) if (scl === 1'b1) begin
    s_stops++; s_mode = 0; s_oe = 1'b0;
  end
  always @(posedge scl) begin
    if (s_mode == 1 || s_mode == 2) begin
      if (s_bc < 8) begin s_sh = {s_sh[6:0], sda}; s_bc++; end
      else begin s_bc = 0; s_after = 1'b1; end
    end else if (s_mode == 3) begin
      if (s_bc < 8) s_bc++;
      else begin s_mnack = sda; s_bc = 0; s_after = 1'b1; end
    end
  end
  always @(negedge scl) begin
    if (s_after) begin
      s_after = 1'b0; s_oe = 1'b0;
      if (s_mode == 3) begin
        if (!s_mnack) begin
          s_txb = s_next; s_next = s_next + 8'h3B;
          if (s_ntx < 4) s_tx[s_ntx] = s_txb;
          s_ntx++;
          s_oe = !s_txb[7];
        end else s_mode = 4;
      end
    end else if (s_bc == 8) begin
      if (s_mode == 1) begin
        if (s_sh[7:1] == SLV) begin
          s_oe = 1'b1; s_mnack = 1'b0; s_mode = s_sh[0] ? 3 : 2;
        end else s_mode = 4;
      end else if (s_mode == 2) begin
        if (s_nrx < 4) s_rx[s_nrx] = s_sh;
        s_nrx++;
        s_oe = !s_nack_data;
      end else if (s_mode == 3) s_oe = 1'b0;
    end else if (s_mode == 3 && s_bc >= 1 && s_bc <= 7) begin
      s_oe = !s_txb[7 - s_bc];
    end
  end

  int total = 0, bad = 0;
  logic finished = 1'b0;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [15:0] mk_cmd(input logic [6:0] a, input logic wr,
                                         input logic two, input logic hold);
    return {2'b10, hold, 1'b0, two, wr, 2'b00, a, 1'b0};
  endfunction

  task automatic run_cmd(input logic [6:0] a, input logic wr, input logic two,
                         input logic hold, input logic [15:0] d);
    logic [15:0] v;
    int st0, sp0, nb;
    logic exp_err;
    nb = two ? 2 : 1;
    exp_err = (a != SLV) || (wr && s_nack_data);
    wr_reg(3'd0, 16'hE000);
    if (wr) wr_reg(3'd2, d);
    st0 = s_starts; sp0 = s_stops;
    wr_reg(3'd3, mk_cmd(a, wr, two, hold));
    chk("R3 busy after command", 16'(busy), 16'd1);
    wait_idle();
    rd_reg(3'd0, v);
    if (exp_err) chk("R5 error event", v, 16'h2000);
    else if (wr) chk("R3 transmit event", v, 16'h4000);
    else         chk("R4 receive event", v, 16'h8000);
    chk("R11 one start per command", 16'(s_starts - st0), 16'd1);
    chk("R6 stop count", 16'(s_stops - sp0), (hold && !exp_err) ? 16'd0 : 16'd1);
    chk("R6 scl state after command", 16'(scl_lo), 16'(hold && !exp_err));
    if (!exp_err && wr) begin
      chk("R3 bytes seen by target", 16'(s_nrx), 16'(nb));
      chk("R3 first byte from ext[7:0]", 16'(s_rx[0]), 16'(d[7:0]));
      if (two) chk("R3 second byte from ext[15:8]", 16'(s_rx[1]), 16'(d[15:8]));
    end
    if (!exp_err && !wr) begin
      rd_reg(3'd4, v);
      chk("R4 bytes sent by target (last NACKed)", 16'(s_ntx), 16'(nb));
      chk("R4 first byte in rext[7:0]", 16'(v[7:0]), 16'(s_tx[0]));
      if (two) chk("R4 second byte in rext[15:8]", 16'(v[15:8]), 16'(s_tx[1]));
    end
  endtask

  initial begin : wdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] v;
    int st0;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    // R1 reset state
    rd_reg(3'd0, v); chk("R1 status zero", v, 16'h0000);
    rd_reg(3'd1, v); chk("R1 enable zero", v, 16'h0000);
    chk("R1 irq low", 16'(irq), 16'd0);
    chk("R1 busy low", 16'(busy), 16'd0);
    chk("R1 lines released", 16'({scl_lo, sda_lo}), 16'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 lines released after reset", 16'({scl_lo, sda_lo}), 16'd0);

    // R10 register map
    wr_reg(3'd1, 16'hFFFF); rd_reg(3'd1, v); chk("R10 enable keeps 15:13", v, 16'hE000);
    wr_reg(3'd1, 16'h0000);
    wr_reg(3'd2, 16'h1234); rd_reg(3'd2, v); chk("R10 wext readback", v, 16'h1234);
    rd_reg(3'd5, v); chk("R10 offset 5 reads zero", v, 16'h0000);

    // R2 non-native command ignored
    st0 = s_starts;
    wr_reg(3'd3, 16'h4000 | mk_cmd(SLV, 1'b1, 1'b0, 1'b0) & 16'h3FFF);
    repeat (40) @(negedge clk);
    chk("R2 no busy", 16'(busy), 16'd0);
    chk("R2 no start", 16'(s_starts - st0), 16'd0);
    rd_reg(3'd0, v); chk("R2 no event", v, 16'h0000);
    rd_reg(3'd3, v); chk("R10 cmd unchanged by rejected write", v, 16'h0000);

    // directed transfers
    run_cmd(SLV, 1'b1, 1'b0, 1'b0, 16'h00C3);
    rd_reg(3'd3, v); chk("R10 cmd readback", v, mk_cmd(SLV, 1'b1, 1'b0, 1'b0));
    run_cmd(SLV, 1'b0, 1'b1, 1'b0, 16'h0000);
    run_cmd(7'h21, 1'b1, 1'b1, 1'b0, 16'hBEEF);
    run_cmd(SLV, 1'b1, 1'b1, 1'b1, 16'h5AA5);
    run_cmd(SLV, 1'b0, 1'b1, 1'b1, 16'h0000);
    run_cmd(SLV, 1'b0, 1'b0, 1'b0, 16'h0000);
    s_nack_data = 1'b1;
    run_cmd(SLV, 1'b1, 1'b1, 1'b0, 16'h7E81);
    s_nack_data = 1'b0;

    // R7 / R8 status clearing and interrupt
    wr_reg(3'd1, 16'h8000);
    run_cmd(SLV, 1'b0, 1'b0, 1'b0, 16'h0000);
    @(negedge clk); chk("R8 irq on enabled rx", 16'(irq), 16'd1);
    wr_reg(3'd1, 16'h6000);
    @(negedge clk); chk("R8 irq off when masked", 16'(irq), 16'd0);
    wr_reg(3'd1, 16'h8000);
    wr_reg(3'd0, 16'h6000); rd_reg(3'd0, v); chk("R7 write 0 keeps bit", v, 16'h8000);
    chk("R8 irq still set", 16'(irq), 16'd1);
    wr_reg(3'd0, 16'h8000); rd_reg(3'd0, v); chk("R7 write 1 clears", v, 16'h0000);
    chk("R8 irq cleared", 16'(irq), 16'd0);
    wr_reg(3'd1, 16'h0000);

    // R9 command during busy ignored
    st0 = s_starts;
    wr_reg(3'd2, 16'h0011);
    wr_reg(3'd3, mk_cmd(SLV, 1'b1, 1'b0, 1'b0));
    wr_reg(3'd3, mk_cmd(7'h11, 1'b0, 1'b1, 1'b1));
    wait_idle();
    chk("R9 single start", 16'(s_starts - st0), 16'd1);
    rd_reg(3'd0, v); chk("R9 only first command completed", v, 16'h4000);
    rd_reg(3'd3, v); chk("R9 cmd register kept first", v, mk_cmd(SLV, 1'b1, 1'b0, 1'b0));
    chk("R9 bus released", 16'(scl_lo), 16'd0);

    // seeded random mix
    for (int i = 0; i < 26; i++) begin
      logic [6:0] a;
      logic wr, two, hold;
      a = ($urandom % 5 == 0) ? 7'h33 : SLV;
      wr = 1'($urandom);
      two = 1'($urandom);
      hold = (i < 25) && ($urandom % 3 == 0);
      s_nack_data = wr && ($urandom % 6 == 0);
      run_cmd(a, wr, two, hold, 16'($urandom));
    end
    s_nack_data = 1'b0;

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule